// File: doc/BRIEF.md
# Dual-Bank Interrupt Request Controller

This block collects sixteen normal-priority interrupt sources into two byte-wide banks and eight fast-interrupt sources into a third bank. Each bank exposes three registers: a status byte, a software-written enable (mask) byte, and a request byte. The request byte is the status byte ANDed with the enable byte. A combined normal interrupt output and a combined fast interrupt output are driven from the request bytes.

Bank A mixes live and latched sources. Two active-low level inputs and a constant-one bit are live. A falling-edge line, a rising-edge line, a power-on flag and two timer reload pulses are latched. Latched bits stay set until software writes ones to the bank A request address. Only the latched positions can be cleared this way. Bank B and the fast bank hold only live sources. A control read address reports the present level of both edge lines. All source inputs are assumed to be already synchronous to `clk`.

The power-on flag is held by a two-state machine. State `POR_PENDING` is entered at reset and sets the flag. Transition `POR_PENDING -> POR_DONE` is taken on a clear write whose bit 4 is one. State `POR_DONE` keeps the flag clear and loops on itself until the next reset.

Top module: `irq_hub`

## Requirements
- R1: After reset, all three enable registers read 0x00, bank A status reads 0x90 (power-on bit 4 and constant bit 7) with idle inputs, and both interrupt outputs are low.
- R2: Bank A bits 0 and 1 are the live, inverted values of the two active-low level inputs, and bit 7 always reads 1.
- R3: A high-to-low change of the falling-edge line sets bank A bit 2. A low-to-high change of the rising-edge line sets bank A bit 3. Both bits stay set after the line returns, and the status is readable one clock after the change.
- R4: A one-cycle pulse on timer 0 or timer 1 reload sets bank A bit 5 or bit 6 respectively, and the bit stays set.
- R5: A write to offset 0x05 clears exactly the status bits where the written data AND 0x7C is one. The level bits 0 and 1 and the constant bit 7 are never changed by it.
- R6: When a source sets a latched bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R7: Bank B status (offset 0x08) bits 0 to 5 are the inverted active-low level inputs, bit 6 is serial transmit done, and bit 7 is serial receive done. All of these are live, active-high flags.
- R8: Fast bank status (offset 0x0C) bits 0 and 1 are active-high inputs, bits 2 to 6 are inverted active-low inputs, and bit 7 always reads 1.
- R9: The enable registers at offsets 0x06, 0x0A and 0x0E are written and read back. The request reads at 0x05, 0x09 and 0x0D return status AND enable for banks A, B and fast respectively.
- R10: `irq_o` is high exactly when the bank A or bank B request is nonzero. `fiq_o` is high exactly when the fast request is nonzero.
- R11: Offset 0x00 reads the falling-edge line level in bit 6 and the rising-edge line level in bit 7, with all other bits 0. Unmapped offsets read 0. Writes to the status and request offsets 0x04, 0x08, 0x09, 0x0C and 0x0D change nothing.
- R12: Once the power-on bit has been cleared it stays clear until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word offset |
| reg_wr | input | 1 | Write strobe, committed on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| a_lvl_n | input | 2 | Bank A active-low level sources (bits 0, 1) |
| a_fall_line | input | 1 | Falling-edge-sensitive source |
| a_rise_line | input | 1 | Rising-edge-sensitive source |
| tmr0_reload | input | 1 | Timer 0 reload pulse |
| tmr1_reload | input | 1 | Timer 1 reload pulse |
| b_lvl_n | input | 6 | Bank B active-low level sources |
| ser_tx_done | input | 1 | Serial transmit finished, active high |
| ser_rx_done | input | 1 | Serial receive finished, active high |
| f_hi | input | 2 | Fast active-high sources |
| f_lo_n | input | 5 | Fast active-low sources |
| irq_o | output | 1 | Combined normal interrupt |
| fiq_o | output | 1 | Combined fast interrupt |

## Verification
Bank A is driven with a level input held and released, to show that level bits follow the pin while edge, timer and power-on bits hold their value. Clear writes use a single-bit pattern and then an all-ones pattern while a level input is active. This separates a correctly masked clear from one that also clears live or constant bits. A clear that lands in the same cycle as a timer pulse shows which side wins. Enable patterns that pick one set bit per bank show that requests and both combined outputs follow status AND enable, and that they do not react to status alone.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_A_STS = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_A_REQ = 5'h05;
    localparam logic [ADDR_W-1:0] OFS_A_MSK = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_B_STS = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_B_REQ = 5'h09;
    localparam logic [ADDR_W-1:0] OFS_B_MSK = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_F_STS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_F_REQ = 5'h0D;
    localparam logic [ADDR_W-1:0] OFS_F_MSK = 5'h0E;

    // bank A bit positions
    localparam int A_FALL = 2;
    localparam int A_RISE = 3;
    localparam int A_POR  = 4;
    localparam int A_TM0  = 5;
    localparam int A_TM1  = 6;
    localparam int A_ONE  = 7;

    localparam logic [DATA_W-1:0] A_CLR_MASK = 8'h7C;

    typedef enum logic {
        POR_PENDING = 1'b0,
        POR_DONE    = 1'b1
    } por_state_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic clr_i,
    output logic flag_o
);
    logic prev_q;
    logic hit;
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RISING ? 1'b1 : 1'b0;
        else        prev_q <= line_i;
    end

    always_comb begin
        if (RISING) hit = line_i & ~prev_q;
        else        hit = prev_q & ~line_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R6: detection beats a clear in the same cycle
    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_i) |=> flag_o);
endmodule

// File: rtl/irq_bank_a.sv
module irq_bank_a
    import irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lvl_n,
    input  logic              fall_line,
    input  logic              rise_line,
    input  logic              tmr0_reload,
    input  logic              tmr1_reload,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] sts_o
);
    localparam int N_EDGE = 2;
    localparam int N_TMR  = 2;

    logic [DATA_W-1:0] clr_bits;
    logic [N_EDGE-1:0] edge_line;
    logic [N_EDGE-1:0] edge_flag;
    logic [N_TMR-1:0]  tmr_pulse;
    logic [N_TMR-1:0]  tmr_flag;
    por_state_t        por_q;
    por_state_t        por_d;
    logic              por_flag;

    assign clr_bits  = clr_stb ? (clr_data & A_CLR_MASK) : '0;
    assign edge_line = {rise_line, fall_line};
    assign tmr_pulse = {tmr1_reload, tmr0_reload};

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        irq_edge_latch #(.RISING(g == 1)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (edge_line[g]),
            .clr_i  (clr_bits[A_FALL + g]),
            .flag_o (edge_flag[g])
        );
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    flag_q <= 1'b0;
            else if (tmr_pulse[g])         flag_q <= 1'b1;
            else if (clr_bits[A_TM0 + g])  flag_q <= 1'b0;
        end
        assign tmr_flag[g] = flag_q;

        // R4: a reload pulse always leaves the bit set
        assert_tmr_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_pulse[g] |=> sts_o[A_TM0 + g]);
        // R5: a clear without a new pulse removes the bit
        assert_tmr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && clr_data[A_TM0 + g] && !tmr_pulse[g]) |=> !sts_o[A_TM0 + g]);
    end

    // power-on flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) por_q <= POR_PENDING;
        else        por_q <= por_d;
    end

    // power-on flag next state and output
    always_comb begin
        por_d    = por_q;
        por_flag = 1'b0;
        unique case (por_q)
            POR_PENDING: begin
                por_flag = 1'b1;
                if (clr_bits[A_POR]) por_d = POR_DONE;
            end
            POR_DONE: begin
                por_flag = 1'b0;
                por_d    = POR_DONE;
            end
        endcase
    end

    assign sts_o = {1'b1, tmr_flag, por_flag, edge_flag, ~lvl_n};

    // R3: edges seen on the lines land in the status byte
    assert_fall_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(fall_line)) |=> sts_o[A_FALL]);
    assert_rise_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rise_line)) |=> sts_o[A_RISE]);
    // R12: the power-on bit never returns once cleared
    assert_por_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_o[A_POR] |=> !sts_o[A_POR]);
    // R5: level bits follow the pins regardless of clear writes
    assert_lvl_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !$stable(lvl_n)) |-> (sts_o[1:0] == ~lvl_n));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sts_a,
    input  logic [DATA_W-1:0] sts_b,
    input  logic [DATA_W-1:0] sts_f,
    input  logic              fall_line,
    input  logic              rise_line,
    output logic              clr_a_stb,
    output logic [DATA_W-1:0] req_a,
    output logic [DATA_W-1:0] req_b,
    output logic [DATA_W-1:0] req_f,
    output logic [DATA_W-1:0] rdata
);
    localparam int N_BANK = 3;

    logic [ADDR_W-1:0] msk_ofs [N_BANK];
    logic [DATA_W-1:0] msk_q   [N_BANK];

    assign msk_ofs[0] = OFS_A_MSK;
    assign msk_ofs[1] = OFS_B_MSK;
    assign msk_ofs[2] = OFS_F_MSK;

    for (genvar g = 0; g < N_BANK; g++) begin : g_msk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        msk_q[g] <= '0;
            else if (wr && addr == msk_ofs[g]) msk_q[g] <= wdata;
        end

        // R9: an enable write is visible the next cycle
        assert_msk_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == msk_ofs[g]) |=> (msk_q[g] == $past(wdata)));
    end

    assign clr_a_stb = wr && (addr == OFS_A_REQ);

    assign req_a = sts_a & msk_q[0];
    assign req_b = sts_b & msk_q[1];
    assign req_f = sts_f & msk_q[2];

    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = {rise_line, fall_line, 6'b0};
            OFS_A_STS: rdata = sts_a;
            OFS_A_REQ: rdata = req_a;
            OFS_A_MSK: rdata = msk_q[0];
            OFS_B_STS: rdata = sts_b;
            OFS_B_REQ: rdata = req_b;
            OFS_B_MSK: rdata = msk_q[1];
            OFS_F_STS: rdata = sts_f;
            OFS_F_REQ: rdata = req_f;
            OFS_F_MSK: rdata = msk_q[2];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [1:0] a_lvl_n,
    input  logic       a_fall_line,
    input  logic       a_rise_line,
    input  logic       tmr0_reload,
    input  logic       tmr1_reload,
    input  logic [5:0] b_lvl_n,
    input  logic       ser_tx_done,
    input  logic       ser_rx_done,
    input  logic [1:0] f_hi,
    input  logic [4:0] f_lo_n,
    output logic       irq_o,
    output logic       fiq_o
);
    logic [DATA_W-1:0] sts_a;
    logic [DATA_W-1:0] sts_b;
    logic [DATA_W-1:0] sts_f;
    logic [DATA_W-1:0] req_a;
    logic [DATA_W-1:0] req_b;
    logic [DATA_W-1:0] req_f;
    logic              clr_a_stb;

    assign sts_b = {ser_rx_done, ser_tx_done, ~b_lvl_n};
    assign sts_f = {1'b1, ~f_lo_n, f_hi};

    irq_bank_a u_bank_a (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_n       (a_lvl_n),
        .fall_line   (a_fall_line),
        .rise_line   (a_rise_line),
        .tmr0_reload (tmr0_reload),
        .tmr1_reload (tmr1_reload),
        .clr_stb     (clr_a_stb),
        .clr_data    (reg_wdata),
        .sts_o       (sts_a)
    );

    irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .sts_a     (sts_a),
        .sts_b     (sts_b),
        .sts_f     (sts_f),
        .fall_line (a_fall_line),
        .rise_line (a_rise_line),
        .clr_a_stb (clr_a_stb),
        .req_a     (req_a),
        .req_b     (req_b),
        .req_f     (req_f),
        .rdata     (reg_rdata)
    );

    assign irq_o = (|req_a) | (|req_b);
    assign fiq_o = |req_f;

    // R10: the constant fast source alone raises fiq_o once enabled
    assert_fiq_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_f[7] |-> fiq_o);
    // R10: no request bits means no normal interrupt
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_a == '0 && req_b == '0) |-> !irq_o);
    // R8: the fast bank top bit is always set
    assert_fiq_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sts_f[7]);
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam time HALF = 2ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] a_lvl_n = 2'b11;
    logic       a_fall_line = 1'b1;
    logic       a_rise_line = 1'b0;
    logic       tmr0_reload = 1'b0;
    logic       tmr1_reload = 1'b0;
    logic [5:0] b_lvl_n = 6'h3F;
    logic       ser_tx_done = 1'b0;
    logic       ser_rx_done = 1'b0;
    logic [1:0] f_hi = 2'b00;
    logic [4:0] f_lo_n = 5'h1F;
    logic       irq_o;
    logic       fiq_o;

    int n_total = 0;
    int n_fail  = 0;
    logic [7:0] rv;

    always #HALF clk = ~clk;

    irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .a_lvl_n(a_lvl_n),
        .a_fall_line(a_fall_line), .a_rise_line(a_rise_line),
        .tmr0_reload(tmr0_reload), .tmr1_reload(tmr1_reload),
        .b_lvl_n(b_lvl_n), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .f_hi(f_hi), .f_lo_n(f_lo_n), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        rv = reg_rdata;
    endtask

    task automatic t_reset;
        rd(5'h06); check("R1 A enable", rv, 8'h00);
        rd(5'h0A); check("R1 B enable", rv, 8'h00);
        rd(5'h0E); check("R1 fast enable", rv, 8'h00);
        rd(5'h04); check("R1 A status", rv, 8'h90);
        check("R1 irq_o", {7'b0, irq_o}, 8'h00);
        check("R1 fiq_o", {7'b0, fiq_o}, 8'h00);
    endtask

    task automatic t_levels_a;
        @(negedge clk); a_lvl_n = 2'b10;
        rd(5'h04); check("R2 level bit0", rv, 8'h91);
        @(negedge clk); a_lvl_n = 2'b01;
        rd(5'h04); check("R2 level bit1", rv, 8'h92);
        @(negedge clk); a_lvl_n = 2'b11;
        rd(5'h04); check("R2 level released", rv, 8'h90);
    endtask

    task automatic t_edges;
        @(negedge clk); a_fall_line = 1'b0;
        rd(5'h04); check("R3 falling edge", rv, 8'h94);
        @(negedge clk); a_rise_line = 1'b1;
        rd(5'h04); check("R3 rising edge", rv, 8'h9C);
        @(negedge clk); a_rise_line = 1'b0;
        @(negedge clk); a_rise_line = 1'b1;
        rd(5'h04); check("R3 edges held", rv, 8'h9C);
    endtask

    task automatic t_timers;
        @(negedge clk); tmr0_reload = 1'b1;
        @(negedge clk); tmr0_reload = 1'b0;
        rd(5'h04); check("R4 timer0", rv, 8'hBC);
        @(negedge clk); tmr1_reload = 1'b1;
        @(negedge clk); tmr1_reload = 1'b0;
        rd(5'h04); check("R4 timer1", rv, 8'hFC);
    endtask

    task automatic t_clear;
        @(negedge clk); a_lvl_n = 2'b10;
        rd(5'h04); check("R5 before clear", rv, 8'hFD);
        wr(5'h05, 8'h04);
        rd(5'h04); check("R5 single clear", rv, 8'hF9);
        wr(5'h05, 8'hFF);
        rd(5'h04); check("R5 full clear keeps level and const", rv, 8'h81);
        @(negedge clk); a_lvl_n = 2'b11;
        rd(5'h04); check("R12 power-on stays clear", rv, 8'h80);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        reg_addr = 5'h05; reg_wdata = 8'h20; reg_wr = 1'b1; tmr0_reload = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tmr0_reload = 1'b0;
        rd(5'h04); check("R6 set beats clear", rv, 8'hA0);
        wr(5'h05, 8'h20);
        rd(5'h04); check("R6 later clear", rv, 8'h80);
        wr(5'h05, 8'h10);
        rd(5'h04); check("R12 power-on after re-clear", rv, 8'h80);
    endtask

    task automatic t_bank_b;
        @(negedge clk); b_lvl_n = 6'b011110;
        rd(5'h08); check("R7 B levels", rv, 8'h21);
        @(negedge clk); ser_tx_done = 1'b1;
        rd(5'h08); check("R7 tx done", rv, 8'h61);
        @(negedge clk); ser_rx_done = 1'b1;
        rd(5'h08); check("R7 rx done", rv, 8'hE1);
        check("R10 status alone no irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_fiq;
        rd(5'h0C); check("R8 fast idle", rv, 8'h80);
        @(negedge clk); f_hi = 2'b01; f_lo_n = 5'b11110;
        rd(5'h0C); check("R8 fast mixed", rv, 8'h85);
        @(negedge clk); f_hi = 2'b10; f_lo_n = 5'b01111;
        rd(5'h0C); check("R8 fast other", rv, 8'hC2);
        @(negedge clk); f_hi = 2'b01; f_lo_n = 5'b11110;
    endtask

    task automatic t_masks;
        wr(5'h06, 8'h81);
        rd(5'h06); check("R9 A enable readback", rv, 8'h81);
        rd(5'h05); check("R9 A request", rv, 8'h80);
        check("R10 irq from A", {7'b0, irq_o}, 8'h01);
        wr(5'h06, 8'h00);
        check("R10 irq off", {7'b0, irq_o}, 8'h00);
        wr(5'h0A, 8'h40);
        rd(5'h0A); check("R9 B enable readback", rv, 8'h40);
        rd(5'h09); check("R9 B request", rv, 8'h40);
        check("R10 irq from B", {7'b0, irq_o}, 8'h01);
        wr(5'h0A, 8'h00);
        check("R10 fiq idle", {7'b0, fiq_o}, 8'h00);
        wr(5'h0E, 8'h04);
        rd(5'h0E); check("R9 fast enable readback", rv, 8'h04);
        rd(5'h0D); check("R9 fast request", rv, 8'h04);
        check("R10 fiq on", {7'b0, fiq_o}, 8'h01);
        wr(5'h0E, 8'h00);
        check("R10 fiq off", {7'b0, fiq_o}, 8'h00);
    endtask

    task automatic t_ignored;
        wr(5'h04, 8'h00);
        rd(5'h04); check("R11 A status write ignored", rv, 8'h80);
        wr(5'h08, 8'h00);
        wr(5'h09, 8'hFF);
        rd(5'h08); check("R11 B status write ignored", rv, 8'hE1);
        rd(5'h0A); check("R11 B enable untouched", rv, 8'h00);
        wr(5'h0C, 8'h00);
        wr(5'h0D, 8'hFF);
        rd(5'h0C); check("R11 fast status write ignored", rv, 8'h85);
        rd(5'h0E); check("R11 fast enable untouched", rv, 8'h00);
        rd(5'h10); check("R11 unmapped reads zero", rv, 8'h00);
    endtask

    task automatic t_control;
        @(negedge clk); a_fall_line = 1'b1; a_rise_line = 1'b0;
        rd(5'h00); check("R11 control fall high", rv, 8'h40);
        @(negedge clk); a_fall_line = 1'b0; a_rise_line = 1'b1;
        rd(5'h00); check("R11 control rise high", rv, 8'h80);
        rd(5'h04); check("R3 edges from control toggle", rv, 8'h8C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_levels_a;
        t_edges;
        t_timers;
        t_clear;
        t_set_wins;
        t_bank_b;
        t_fiq;
        t_masks;
        t_ignored;
        t_control;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule